// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose calling convention slides a register window on every call and return. The pipeline always addresses 32 architectural registers with a 5-bit number. Eight of them are globals that never move. The other 24 are taken from the current window of a larger physical array.

The windows overlap, so no values have to be copied on a call. The registers a caller writes as its outgoing arguments are the same physical registers the callee reads as its incoming arguments. Each window also has eight private locals. A window pointer selects the current window. A save (call) moves the pointer down by one and a restore (return) moves it up by one, both wrapping modulo the window count.

A per-window invalid mask comes in from the surrounding control logic. A move into a window marked invalid is refused, and the block flags it as overflow (on a save) or underflow (on a restore) so that the trap logic outside can spill or fill. The register array has two combinational read ports and one write port that is written on the clock edge.

Top module: `rf_window_file`

## Requirements
- R1: After an asynchronous reset (rst_ni low), cwp_o is 0 and overflow_o and underflow_o are low while no move is requested.
- R2: Architectural registers 1 to 7 are globals. They hold the same value whatever the window pointer is.
- R3: Register 0 always reads as zero. A write to register 0 is discarded.
- R4: Registers 16 to 23 are locals and are private to each window. A write to a local in one window does not change a local of any other window.
- R5: Registers 8 to 15 (outs) of window w are the same physical registers as registers 24 to 31 (ins) of window (w-1) mod NWIN. After a save, a value written to out k is read back as in k.
- R6: A save that is taken sets the pointer to (cwp-1) mod NWIN. A restore that is taken sets it to (cwp+1) mod NWIN. The new pointer is visible one clock edge after the request.
- R7: If save_i is high and bit (cwp-1) mod NWIN of win_invalid_i is set, overflow_o is high in that same cycle and the pointer does not move. Other mask bits never raise overflow_o.
- R8: If restore_i is high (save_i low) and bit (cwp+1) mod NWIN of win_invalid_i is set, underflow_o is high in that same cycle and the pointer does not move.
- R9: If save_i and restore_i are both high, the save is handled (moved or flagged as overflow) and the restore is ignored. underflow_o stays low.
- R10: A read of the register being written in the same cycle returns the old value. The new value is readable from the next cycle on.
- R11: A write issued in the same cycle as a save or restore uses the window pointer from before the move.
- R12: The two read ports are independent. Each returns the register its own address selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_addr_i | input | 5 | Read port A architectural register number |
| ra_data_o | output | XLEN | Read port A data (combinational) |
| rb_addr_i | input | 5 | Read port B architectural register number |
| rb_data_o | output | XLEN | Read port B data (combinational) |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 5 | Write architectural register number |
| wd_data_i | input | XLEN | Write data |
| save_i | input | 1 | Request a window move for a call |
| restore_i | input | 1 | Request a window move for a return |
| win_invalid_i | input | NWIN | Per-window invalid mask |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Save refused: target window invalid |
| underflow_o | output | 1 | Restore refused: target window invalid |

## Verification
A register write and a window move can happen on the same clock edge. The write must be decoded with the pointer from before the edge, not the one after. The bench issues a write to a local together with a save, then restores and reads that local back in the original window. It also reads the neighbouring window's local to confirm that the write did not land there. A second collision, save and restore requested together, is also provoked: once with the target valid and once with it invalid. The pointer and both flags are judged against the save-wins rule.

// File: rtl/rf_win_pkg.sv
package rf_win_pkg;
  localparam int unsigned ARCH_W   = 5;
  localparam int unsigned GLOB_N   = 8;
  localparam int unsigned WIN_REGS = 16;

  typedef enum logic [1:0] {
    GRP_GLOB = 2'b00,
    GRP_OUT  = 2'b01,
    GRP_LOC  = 2'b10,
    GRP_IN   = 2'b11
  } reg_grp_e;

  function automatic int unsigned win_below(int unsigned w, int unsigned n);
    return (w == 0) ? n - 1 : w - 1;
  endfunction
endpackage

// File: rtl/rf_win_map.sv
module rf_win_map
  import rf_win_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = 3,
  parameter int unsigned PA_W  = 8
) (
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [ARCH_W-1:0] arch_i,
  output logic [PA_W-1:0]   phys_o
);
  int unsigned idx;
  reg_grp_e    grp;

  assign grp = reg_grp_e'(arch_i[4:3]);

  // window w: ins at base+0..7, locals at base+8..15; outs alias ins of w-1
  always_comb begin
    unique case (grp)
      GRP_GLOB: idx = int'(arch_i[2:0]);
      GRP_OUT:  idx = GLOB_N + WIN_REGS * win_below(int'(cwp_i), NWIN) + int'(arch_i[2:0]);
      GRP_LOC:  idx = GLOB_N + WIN_REGS * int'(cwp_i) + 8 + int'(arch_i[2:0]);
      default:  idx = GLOB_N + WIN_REGS * int'(cwp_i) + int'(arch_i[2:0]);
    endcase
    phys_o = PA_W'(idx);
  end
endmodule

// File: rtl/rf_win_ctrl.sv
module rf_win_ctrl #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [NWIN-1:0]  win_invalid_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam logic [CWP_W-1:0] LAST = CWP_W'(NWIN - 1);

  logic [CWP_W-1:0] cwp_q, cwp_d, cwp_dn, cwp_up;
  logic             ovf, unf, rst_go;

  assign cwp_dn = (cwp_q == '0)  ? LAST : cwp_q - 1'b1;
  assign cwp_up = (cwp_q == LAST) ? '0   : cwp_q + 1'b1;

  // save has priority over restore
  assign rst_go = restore_i & ~save_i;
  assign ovf    = save_i & win_invalid_i[cwp_dn];
  assign unf    = rst_go & win_invalid_i[cwp_up];

  always_comb begin
    cwp_d = cwp_q;
    if (save_i && !ovf)      cwp_d = cwp_dn;
    else if (rst_go && !unf) cwp_d = cwp_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cwp_q <= '0;
    else         cwp_q <= cwp_d;
  end

  assign cwp_o       = cwp_q;
  assign overflow_o  = ovf;
  assign underflow_o = unf;

  p_save_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i && !overflow_o |=>
      cwp_q == (($past(cwp_q) == '0) ? LAST : $past(cwp_q) - 1'b1));

  p_rest_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !save_i && !underflow_o |=>
      cwp_q == (($past(cwp_q) == LAST) ? '0 : $past(cwp_q) + 1'b1));

  p_no_overflow_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> $stable(cwp_q));

  p_no_underflow_move_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> $stable(cwp_q));

  p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && underflow_o));
endmodule

// File: rtl/rf_win_array.sv
module rf_win_array #(
  parameter int unsigned NPHYS = 136,
  parameter int unsigned PA_W  = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NRD   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [PA_W-1:0]            waddr_i,
  input  logic [XLEN-1:0]            wdata_i,
  input  logic [NRD-1:0][PA_W-1:0]   raddr_i,
  output logic [NRD-1:0][XLEN-1:0]   rdata_o
);
  logic [XLEN-1:0] mem_q [NPHYS];
  logic            wr_ok;

  // physical 0 is the hard zero; never stored
  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : mem_q[raddr_i[p]];
  end

  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rf_window_file.sv
module rf_window_file
  import rf_win_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [4:0]               ra_addr_i,
  output logic [XLEN-1:0]          ra_data_o,
  input  logic [4:0]               rb_addr_i,
  output logic [XLEN-1:0]          rb_data_o,
  input  logic                     we_i,
  input  logic [4:0]               wa_addr_i,
  input  logic [XLEN-1:0]          wd_data_i,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic [NWIN-1:0]          win_invalid_i,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic                     overflow_o,
  output logic                     underflow_o
);
  localparam int unsigned CWP_W = $clog2(NWIN);
  localparam int unsigned NPHYS = GLOB_N + WIN_REGS * NWIN;
  localparam int unsigned PA_W  = $clog2(NPHYS);
  localparam int unsigned NRD   = 2;
  localparam int unsigned NMAP  = NRD + 1;

  logic [CWP_W-1:0]               cwp;
  logic [NMAP-1:0][ARCH_W-1:0]    arch_a;
  logic [NMAP-1:0][PA_W-1:0]      phys_a;
  logic [NRD-1:0][XLEN-1:0]       rdata;

  assign arch_a[0] = ra_addr_i;
  assign arch_a[1] = rb_addr_i;
  assign arch_a[NRD] = wa_addr_i;

  rf_win_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .win_invalid_i(win_invalid_i),
    .cwp_o        (cwp),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
  );

  // write decodes with the pre-move pointer: cwp is the registered value
  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rf_win_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PA_W(PA_W)) u_map (
      .cwp_i (cwp),
      .arch_i(arch_a[m]),
      .phys_o(phys_a[m])
    );
  end

  rf_win_array #(.NPHYS(NPHYS), .PA_W(PA_W), .XLEN(XLEN), .NRD(NRD)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(phys_a[NRD]),
    .wdata_i(wd_data_i),
    .raddr_i(phys_a[NRD-1:0]),
    .rdata_o(rdata)
  );

  assign ra_data_o = rdata[0];
  assign rb_data_o = rdata[1];
  assign cwp_o     = cwp;

  p_zero_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == '0) |-> (ra_data_o == '0));

  p_glob_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && (ra_addr_i[4:3] == 2'b00) && $stable(ra_addr_i) && !$past(we_i)
      |-> $stable(ra_data_o));
endmodule

// File: tb/tb_rf_window_file.sv
`timescale 1ns/1ps
module tb_rf_window_file;
  localparam int N = 4;
  localparam int XL = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    ra_addr_i = '0, rb_addr_i = '0, wa_addr_i = '0;
  logic [XL-1:0] ra_data_o, rb_data_o, wd_data_i = '0;
  logic          we_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [N-1:0]  win_invalid_i = '0;
  logic [1:0]    cwp_o;
  logic          overflow_o, underflow_o;

  int checks = 0, fails = 0, cwp_m = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rf_window_file #(.NWIN(N), .XLEN(XL)) dut (.*);

  function automatic logic [31:0] g_tag(int k);      return 32'h6000_0000 | k; endfunction
  function automatic logic [31:0] l_tag(int w, int k); return 32'hC000_0000 | (w << 8) | k; endfunction
  function automatic logic [31:0] i_tag(int w, int k); return 32'hB000_0000 | (w << 8) | k; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk_i); #1; endtask

  task automatic wr(int a, logic [31:0] d);
    we_i = 1'b1; wa_addr_i = 5'(a); wd_data_i = d;
    tick();
    we_i = 1'b0;
  endtask

  task automatic rd_a(int a, output logic [31:0] d);
    ra_addr_i = 5'(a); #0.5; d = ra_data_o;
  endtask

  task automatic mv(bit s, bit r, bit eo, bit eu, int ecwp, string req);
    save_i = s; restore_i = r; #0.5;
    chk({req, " ovf"}, 32'(overflow_o), 32'(eo));
    chk({req, " unf"}, 32'(underflow_o), 32'(eu));
    tick();
    save_i = 1'b0; restore_i = 1'b0;
    cwp_m = ecwp;
    chk({req, " cwp"}, 32'(cwp_o), 32'(ecwp));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    // R1 reset state
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 ovf", 32'(overflow_o), 0);
    chk("R1 unf", 32'(underflow_o), 0);
    rst_ni = 1'b1;
    tick();

    // R3 zero register
    wr(0, 32'hFFFF_FFFF);
    rd_a(0, d); chk("R3 r0", d, 0);

    for (int k = 1; k < 8; k++) wr(k, g_tag(k));

    // fill every window's locals and ins, stepping down by saves
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 8; k++) begin
        wr(16 + k, l_tag(cwp_m, k));
        wr(24 + k, i_tag(cwp_m, k));
      end
      mv(1, 0, 0, 0, (cwp_m + N - 1) % N, "R6 save");
    end
    chk("R6 wrap", 32'(cwp_m), 0);

    // sweep every window by restores
    for (int i = 0; i < N; i++) begin
      for (int k = 1; k < 8; k++) begin rd_a(k, d); chk("R2 glob", d, g_tag(k)); end
      for (int k = 0; k < 8; k++) begin
        rd_a(16 + k, d); chk("R4 local", d, l_tag(cwp_m, k));
        rd_a(8 + k, d);  chk("R5 out=in(w-1)", d, i_tag((cwp_m + N - 1) % N, k));
        rb_addr_i = 5'(24 + k); #0.5;
        chk("R12 port b", rb_data_o, i_tag(cwp_m, k));
        chk("R12 port a", ra_data_o, i_tag((cwp_m + N - 1) % N, k));
      end
      mv(0, 1, 0, 0, (cwp_m + 1) % N, "R6 restore");
    end

    // R5 out written, read as in after save
    wr(13, 32'h0D0D_0005);
    mv(1, 0, 0, 0, (cwp_m + N - 1) % N, "R5 save");
    rd_a(29, d); chk("R5 out->in", d, 32'h0D0D_0005);
    mv(0, 1, 0, 0, (cwp_m + 1) % N, "R5 restore");

    // R10 same-cycle read of written register
    ra_addr_i = 5'd17; we_i = 1'b1; wa_addr_i = 5'd17; wd_data_i = 32'h1234_5678;
    #0.5; chk("R10 old", ra_data_o, l_tag(cwp_m, 1));
    tick(); we_i = 1'b0;
    chk("R10 new", ra_data_o, 32'h1234_5678);

    // R11 write together with save lands in the old window
    we_i = 1'b1; wa_addr_i = 5'd18; wd_data_i = 32'hAAAA_0011;
    mv(1, 0, 0, 0, (cwp_m + N - 1) % N, "R11 save");
    we_i = 1'b0;
    rd_a(18, d); chk("R11 new win untouched", d, l_tag(cwp_m, 2));
    mv(0, 1, 0, 0, (cwp_m + 1) % N, "R11 restore");
    rd_a(18, d); chk("R11 old win", d, 32'hAAAA_0011);

    // R7 overflow: target invalid, then only non-target invalid
    for (int w = 0; w < N; w++) begin
      win_invalid_i = N'(1 << ((cwp_m + N - 1) % N));
      mv(1, 0, 1, 0, cwp_m, "R7 ovf");
      win_invalid_i = ~N'(1 << ((cwp_m + N - 1) % N));
      mv(1, 0, 0, 0, (cwp_m + N - 1) % N, "R7 other bits");
    end
    // R8 underflow
    for (int w = 0; w < N; w++) begin
      win_invalid_i = N'(1 << ((cwp_m + 1) % N));
      mv(0, 1, 0, 1, cwp_m, "R8 unf");
      win_invalid_i = ~N'(1 << ((cwp_m + 1) % N));
      mv(0, 1, 0, 0, (cwp_m + 1) % N, "R8 other bits");
    end
    // R9 simultaneous requests
    win_invalid_i = '0;
    mv(1, 1, 0, 0, (cwp_m + N - 1) % N, "R9 save wins");
    win_invalid_i = N'(1 << ((cwp_m + N - 1) % N));
    mv(1, 1, 1, 0, cwp_m, "R9 save flagged");
    win_invalid_i = N'(1 << ((cwp_m + 1) % N));
    mv(1, 1, 0, 0, (cwp_m + N - 1) % N, "R9 restore ignored");
    win_invalid_i = '0;

    // R2 globals unchanged after all moves
    rd_a(7, d); chk("R2 glob final", d, g_tag(7));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule